// File: doc/BRIEF.md
# Monochrome Bit-Tripling Word Packer

This block turns a one-bit-per-pixel bitmap, delivered as a byte stream, into 32-bit host data words for a drawing engine. In tripling mode every pixel bit is written out three times in a row. A byte-wide engine that runs a 24-bit framebuffer as 8-bit pixels can then expand each triple into one full pixel. In pass-through mode the input bytes are only gathered four to a word.

A conversion begins with a start pulse that captures the image width, the image height and the mode. The block accepts exactly the number of input bytes that the image needs, each bitmap row starting on a byte boundary. It returns words through a valid/ready port. Backpressure on the word port stalls the byte port, so no data is lost. A single-cycle done pulse marks the end of each conversion.

Top module: `bit_triple_packer`

## Requirements
- R1: A conversion consumes exactly ceil(width/8) x height input bytes. `in_ready` stays low whenever no conversion is running and after the last byte has been taken.
- R2: With `triple_en`=1, each input bit becomes three equal consecutive output bits. The first pixel is input bit 7, and output bytes are filled from bit 7 down to bit 0. For example, an input byte 0x80 with 8 live pixels yields the bytes 0xE0, 0x00, 0x00.
- R3: With `triple_en`=1, the last input byte of a row holds n live pixels (n = width mod 8, or 8 when that is 0). That byte yields ceil(3n/8) output bytes, its bits below the live pixels are ignored, and the unused low bits of the final output byte are zero. The next row starts on a fresh input byte and a fresh output byte.
- R4: Output bytes are placed into a word from the least significant byte upward. The first byte of a word occupies bits [7:0].
- R5: A word is emitted once it holds four bytes, or once the output of the final input byte is complete. The unfilled upper bytes of a final partial word are zero.
- R6: With `triple_en`=0, input bytes are passed through unchanged, four per word with the least significant byte first, giving ceil(bytes/4) words.
- R7: A start with width 0 or height 0 produces no words and raises `done` in the cycle after the start.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` stays unchanged. No word is dropped or repeated.
- R9: `done` is a one-cycle pulse in the cycle after the final word is accepted.
- R10: A start received while a conversion is running is ignored, and `out_valid` is only ever high during a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a conversion; captures width, height and mode |
| img_width | input | IMG_W_BITS | Image width in pixels |
| img_height | input | IMG_H_BITS | Image height in rows |
| triple_en | input | 1 | 1 = tripling mode, 0 = pass-through packing |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Bitmap byte; pixel order is bit 7 first |
| in_ready | output | 1 | Block accepts the input byte |
| out_valid | output | 1 | Output word valid |
| out_word | output | 32 | Host data word, first byte in bits [7:0] |
| out_ready | input | 1 | Consumer accepts the output word |
| done | output | 1 | One-cycle pulse at the end of a conversion |

## Verification
A row or pixel counter that goes wrong shows up within the same row. Either the padding lands in the wrong place inside a word, or the byte count drifts and `in_ready` drops early, or the end of the image is never reached, so `done` never arrives. A fault in the fill position of a word or in the held-word logic corrupts the very next word on the port. A leak between the byte and word handshakes under backpressure shows up as a missing or repeated word. Random images of many widths, heights and stall patterns are therefore compared word by word, and the done pulse is checked against the exact cycle in which the last word is taken.

// File: rtl/btp_pkg.sv
// Package: shared types and pure functions for the bit-tripling packer.
// Assumes pixel order is bit 7 first inside every byte.
package btp_pkg;

    typedef enum logic {
        MODE_PASS   = 1'b0,
        MODE_TRIPLE = 1'b1
    } pack_mode_e;

    // Repeat each bit of a byte three times; bit 7 lands in [23:21].
    function automatic logic [23:0] triple_bits(input logic [7:0] b);
        logic [23:0] t;
        for (int i = 0; i < 8; i++) begin
            t[3*i +: 3] = {3{b[i]}};
        end
        return t;
    endfunction

    // Number of output bytes carried by n live pixels once tripled: ceil(3n/8).
    function automatic logic [1:0] tripled_count(input logic [3:0] n);
        logic [5:0] bits;
        bits = 6'(n) * 6'd3 + 6'd7;
        return bits[4:3];
    endfunction

    // Keep the top n bits of a byte, clear the rest.
    function automatic logic [7:0] live_mask(input logic [3:0] n);
        return 8'(8'hFF << (4'd8 - n));
    endfunction

endpackage

// File: rtl/btp_seq.sv
// Module: btp_seq
// Walks the bitmap row by row and byte by byte, and turns each input byte
// into one to three output bytes (tripling mode) or one byte (pass mode).
// Assumes: the downstream byte sink may stall at any time; a conversion
// is released only when job_end reports that the final word was accepted.
module btp_seq
    import btp_pkg::*;
#(
    parameter int IMG_W_BITS = 12,
    parameter int IMG_H_BITS = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [IMG_W_BITS-1:0] img_w,
    input  logic [IMG_H_BITS-1:0] img_h,
    input  logic                  mode_in,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    output logic                  in_ready,
    output logic                  busy,
    output logic                  zero_start,
    output logic                  byte_valid,
    output logic [7:0]            byte_data,
    output logic                  byte_last,
    input  logic                  byte_ready,
    input  logic                  job_end
);
    localparam int CB_W = IMG_W_BITS - 2;

    pack_mode_e            mode_q;
    logic [CB_W-1:0]       row_bytes;
    logic [2:0]            tail_px;
    logic [CB_W-1:0]       col_left;
    logic [IMG_H_BITS-1:0] rows_left;
    logic                  have;
    logic [23:0]           cur;
    logic [1:0]            nbytes;
    logic [1:0]            sub;
    logic                  cur_last;

    logic                  take_start;
    logic                  in_fire;
    logic                  byte_fire;
    logic                  row_end;
    logic [3:0]            n_live;
    logic [7:0]            masked;
    logic [CB_W-1:0]       row_bytes_new;

    // Start decode: a non-empty image opens a job, an empty one ends at once.
    always_comb begin
        take_start    = start && !busy && (img_w != '0) && (img_h != '0);
        zero_start    = start && !busy && ((img_w == '0) || (img_h == '0));
        row_bytes_new = CB_W'(img_w[IMG_W_BITS-1:3]) + CB_W'(|img_w[2:0]);
    end

    // Per-byte decode: live pixel count at row end and masked input byte.
    always_comb begin
        in_ready  = busy && !have && (rows_left != '0);
        in_fire   = in_valid && in_ready;
        row_end   = (col_left == CB_W'(1));
        n_live    = (row_end && (tail_px != 3'd0)) ? {1'b0, tail_px} : 4'd8;
        masked    = in_data & live_mask(n_live);
        byte_valid = have;
        byte_data  = cur[23:16];
        byte_last  = cur_last && (sub == nbytes - 2'd1);
        byte_fire  = byte_valid && byte_ready;
    end

    // Job state: busy flag, captured geometry and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            mode_q    <= MODE_PASS;
            row_bytes <= '0;
            tail_px   <= '0;
        end else if (take_start) begin
            busy      <= 1'b1;
            mode_q    <= pack_mode_e'(mode_in);
            row_bytes <= row_bytes_new;
            tail_px   <= img_w[2:0];
        end else if (job_end) begin
            busy      <= 1'b0;
        end
    end

    // Position counters: bytes left in the row and rows left in the image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_left  <= '0;
            rows_left <= '0;
        end else if (take_start) begin
            col_left  <= row_bytes_new;
            rows_left <= img_h;
        end else if (in_fire) begin
            col_left <= row_end ? row_bytes : col_left - CB_W'(1);
            if (row_end) rows_left <= rows_left - IMG_H_BITS'(1);
        end
    end

    // Byte holder: load an expanded input byte, then shift out its bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have     <= 1'b0;
            cur      <= '0;
            nbytes   <= '0;
            sub      <= '0;
            cur_last <= 1'b0;
        end else if (in_fire) begin
            have     <= 1'b1;
            sub      <= 2'd0;
            cur_last <= row_end && (rows_left == IMG_H_BITS'(1));
            if (mode_q == MODE_TRIPLE) begin
                cur    <= triple_bits(masked);
                nbytes <= tripled_count(n_live);
            end else begin
                cur    <= {in_data, 16'h0000};
                nbytes <= 2'd1;
            end
        end else if (byte_fire) begin
            if (sub == nbytes - 2'd1) begin
                have <= 1'b0;
            end else begin
                sub <= sub + 2'd1;
                cur <= {cur[15:0], 8'h00};
            end
        end
    end

    // After the final byte leaves, no further input or byte may appear.
    AST_LAST_ENDS_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && byte_ready && byte_last |=> !in_ready && !byte_valid); // R1

endmodule

// File: rtl/btp_pack.sv
// Module: btp_pack
// Gathers bytes into 32-bit words, least significant byte first, and holds
// each finished word until the consumer takes it.
// Assumes: the byte source marks the final byte of a job with byte_last.
module btp_pack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic        byte_last,
    output logic        byte_ready,
    output logic        out_valid,
    output logic [31:0] out_word,
    input  logic        out_ready,
    output logic        job_end
);
    logic [1:0]  fill;
    logic [31:0] word_q;
    logic        valid_q;
    logic        last_q;
    logic        byte_fire;
    logic        word_fire;

    // Handshake decode for both sides of the packer.
    always_comb begin
        byte_ready = !valid_q;
        byte_fire  = byte_valid && byte_ready;
        word_fire  = valid_q && out_ready;
        out_valid  = valid_q;
        out_word   = word_q;
        job_end    = word_fire && last_q;
    end

    // Word assembly: place bytes upward, close on four bytes or job end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill    <= '0;
            word_q  <= '0;
            valid_q <= 1'b0;
            last_q  <= 1'b0;
        end else if (word_fire) begin
            word_q  <= '0;
            valid_q <= 1'b0;
            last_q  <= 1'b0;
        end else if (byte_fire) begin
            word_q[{fill, 3'b000} +: 8] <= byte_data;
            if ((fill == 2'd3) || byte_last) begin
                valid_q <= 1'b1;
                last_q  <= byte_last;
                fill    <= 2'd0;
            end else begin
                fill <= fill + 2'd1;
            end
        end
    end

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word)); // R8
    AST_FULL_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && byte_ready && byte_last |=> out_valid); // R5

endmodule

// File: rtl/bit_triple_packer.sv
// Module: bit_triple_packer (top)
// Converts a 1-bpp bitmap byte stream into 32-bit host words, optionally
// tripling every pixel bit. Assumes one job at a time; start is ignored
// while busy.
module bit_triple_packer #(
    parameter int IMG_W_BITS = 12,
    parameter int IMG_H_BITS = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [IMG_W_BITS-1:0] img_width,
    input  logic [IMG_H_BITS-1:0] img_height,
    input  logic                  triple_en,
    input  logic                  in_valid,
    input  logic [7:0]            in_byte,
    output logic                  in_ready,
    output logic                  out_valid,
    output logic [31:0]           out_word,
    input  logic                  out_ready,
    output logic                  done
);
    logic       seq_busy;
    logic       zero_start;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       byte_last;
    logic       byte_ready;
    logic       job_end;

    btp_seq #(
        .IMG_W_BITS(IMG_W_BITS),
        .IMG_H_BITS(IMG_H_BITS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .img_w     (img_width),
        .img_h     (img_height),
        .mode_in   (triple_en),
        .in_valid  (in_valid),
        .in_data   (in_byte),
        .in_ready  (in_ready),
        .busy      (seq_busy),
        .zero_start(zero_start),
        .byte_valid(byte_valid),
        .byte_data (byte_data),
        .byte_last (byte_last),
        .byte_ready(byte_ready),
        .job_end   (job_end)
    );

    btp_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_valid(byte_valid),
        .byte_data (byte_data),
        .byte_last (byte_last),
        .byte_ready(byte_ready),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_ready (out_ready),
        .job_end   (job_end)
    );

    // Done register: one pulse after the final word or an empty start.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= job_end || zero_start;
    end

    AST_WORD_IN_JOB: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> seq_busy); // R10
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready) || $past(start)); // R9
    AST_EMPTY_JOB: assert property (@(posedge clk) disable iff (!rst_n)
        start && !seq_busy && ((img_width == '0) || (img_height == '0))
        |=> done && !out_valid); // R7

endmodule

// File: tb/bit_triple_packer_bench.sv
`timescale 1ns/1ps
module bit_triple_packer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] img_width = '0;
    logic [11:0] img_height = '0;
    logic        triple_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_ready = 1'b0;
    logic        done;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [7:0]  src_q[$];
    logic [31:0] exp_q[$];
    logic [31:0] got_q[$];

    always #2 clk = ~clk;

    bit_triple_packer u_bit_triple_packer (
        .clk(clk), .rst_n(rst_n), .start(start), .img_width(img_width),
        .img_height(img_height), .triple_en(triple_en), .in_valid(in_valid),
        .in_byte(in_byte), .in_ready(in_ready), .out_valid(out_valid),
        .out_word(out_word), .out_ready(out_ready), .done(done)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Reference model: bytes per row, live pixels, tripling, LSB-first packing.
    task automatic build(input int w, input int h, input bit tri_m, input bit rnd, input logic [7:0] fixed[$]);
        logic [7:0] ob[$];
        int rb;
        int k;
        src_q.delete(); exp_q.delete();
        rb = (w + 7) / 8;
        k = 0;
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < rb; c++) begin
                logic [7:0] b;
                int n;
                b = rnd ? 8'($urandom) : fixed[k];
                k++;
                src_q.push_back(b);
                n = (c == rb - 1 && (w % 8) != 0) ? (w % 8) : 8;
                if (tri_m) begin
                    logic [23:0] t;
                    t = '0;
                    for (int p = 0; p < n; p++) begin
                        t[23-3*p] = b[7-p];
                        t[22-3*p] = b[7-p];
                        t[21-3*p] = b[7-p];
                    end
                    for (int q = 0; q < (3 * n + 7) / 8; q++) ob.push_back(t[23-8*q -: 8]);
                end else begin
                    ob.push_back(b);
                end
            end
        end
        for (int i = 0; i < ob.size(); i += 4) begin
            logic [31:0] wd;
            wd = '0;
            for (int j = 0; j < 4; j++) if (i + j < ob.size()) wd[8*j +: 8] = ob[i+j];
            exp_q.push_back(wd);
        end
    endtask

    task automatic run_job(input int w, input int h, input bit tri_m, input int rdy_pct,
                           input int vld_pct, input bit poke, input string tag);
        int idx;
        bit expect_done;
        bit seen_done;
        bit held;
        logic [31:0] held_word;
        got_q.delete();
        idx = 0; seen_done = 0; held = 0; held_word = '0;
        expect_done = (exp_q.size() == 0);
        @(negedge clk);
        img_width = 12'(w); img_height = 12'(h); triple_en = tri_m;
        start = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        for (int k = 0; k < 4000 && !seen_done; k++) begin
            @(negedge clk);
            start = poke && (k == 4);
            if (k == 4) begin
                img_width = 12'($urandom_range(40)); img_height = 12'($urandom_range(3));
                triple_en = ~tri_m;
            end
            in_valid  = (idx < src_q.size()) && ($urandom_range(99) < vld_pct);
            in_byte   = (idx < src_q.size()) ? src_q[idx] : 8'($urandom);
            out_ready = ($urandom_range(99) < rdy_pct);
            #1;
            if (done || expect_done) begin
                check(done == expect_done, "R9 done timing", 32'(done), 32'(expect_done));
                if (done) seen_done = 1;
            end
            expect_done = 0;
            if (held) begin
                check(out_valid && out_word == held_word, "R8 held word", out_word, held_word);
                held = 0;
            end
            if (out_valid && !out_ready) begin held = 1; held_word = out_word; end
            if (in_valid && in_ready) idx++;
            if (out_valid && out_ready) begin
                if (got_q.size() < exp_q.size())
                    check(out_word == exp_q[got_q.size()], tag, out_word, exp_q[got_q.size()]);
                else
                    check(1'b0, "R10 extra word", out_word, 32'h0);
                got_q.push_back(out_word);
                if (got_q.size() == exp_q.size()) expect_done = 1;
            end
        end
        start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        check(got_q.size() == exp_q.size(), "R5 word count", 32'(got_q.size()), 32'(exp_q.size()));
        check(idx == src_q.size(), "R1 bytes consumed", 32'(idx), 32'(src_q.size()));
        check(seen_done, "R9 done seen", 32'(seen_done), 32'd1);
    endtask

    initial begin
        wait (cyc >= 150000);
        check(1'b0, "R9 watchdog", 32'(cyc), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) cyc++;

    initial begin
        logic [7:0] fx[$];
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        check(!in_ready && !out_valid && !done, "R1 reset idle",
              {29'd0, in_ready, out_valid, done}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R2: single 0x80 byte, 8 pixels, tripled.
        fx = '{8'h80};
        build(8, 1, 1'b1, 1'b0, fx);
        run_job(8, 1, 1'b1, 100, 100, 1'b0, "R2 tripled word");
        check(got_q.size() > 0 && got_q[0] == 32'h000000E0, "R2 literal",
              got_q.size() > 0 ? got_q[0] : 32'hX, 32'h000000E0);

        // R3/R4: width 3, two rows, row padding and byte order.
        fx = '{8'hA0, 8'hFF};
        build(3, 2, 1'b1, 1'b0, fx);
        run_job(3, 2, 1'b1, 60, 70, 1'b0, "R3 row padding");
        check(got_q.size() > 0 && got_q[0] == 32'h80FF80E3, "R4 literal",
              got_q.size() > 0 ? got_q[0] : 32'hX, 32'h80FF80E3);

        // R6/R5: pass mode, 6 bytes -> 2 words, last partial.
        fx = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        build(16, 3, 1'b0, 1'b0, fx);
        run_job(16, 3, 1'b0, 50, 50, 1'b0, "R6 pass word");
        check(got_q.size() == 2 && got_q[1] == 32'h00006655, "R5 partial literal",
              got_q.size() == 2 ? got_q[1] : 32'hX, 32'h00006655);

        // R7: empty images.
        fx.delete();
        build(0, 4, 1'b1, 1'b1, fx);
        run_job(0, 4, 1'b1, 100, 100, 1'b0, "R7 empty width");
        build(9, 0, 1'b0, 1'b1, fx);
        run_job(9, 0, 1'b0, 100, 100, 1'b0, "R7 empty height");

        // R10: start pulse in mid-job must be ignored.
        build(21, 3, 1'b1, 1'b1, fx);
        run_job(21, 3, 1'b1, 40, 60, 1'b1, "R10 ignored start");

        // R8 and random coverage of R2 R3 R6.
        for (int j = 0; j < 40; j++) begin
            int w; int h; bit m;
            w = $urandom_range(40); h = $urandom_range(4); m = 1'($urandom);
            build(w, h, m, 1'b1, fx);
            run_job(w, h, m, 20 + $urandom_range(80), 30 + $urandom_range(70),
                    1'($urandom), m ? "R3 random tripled" : "R6 random pass");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule